// File: doc/BRIEF.md
# Flash Write Protection Controller

This block decides whether a modify instruction reaching a serial flash may be handed to the program/erase executor. A command decoder presents the opcode, the 24-bit-style address, the number of serial clocks counted while the chip was selected, and the status data byte. It raises `cs_rise` for one clock when chip select deasserts. On that clock the controller weighs the write latch, the block-protect code, the hardware lock of the status bits, the deep power-down state, the executor's busy flag and the transaction length. One clock later it answers with a grant pulse for page program, sector erase or chip erase, or with a refusal pulse.

The controller owns the write enable latch, the three block-protect bits, the status-write-disable bit and the deep power-down flag. Status writes complete inside the controller: a granted status write updates the bits directly and raises no grant pulse. Malformed, busy-time and power-down-time instructions leave no trace: no pulse and no state change.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the write latch, block-protect bits, status-write-disable bit and power-down flag are all 0, and no pulse is raised.
- R2: Opcode 0x06 sets the write latch and opcode 0x04 clears it, whatever the clock count, unless the block is in power-down.
- R3: Page program (0x02), sector erase, chip erase and status write (0x01) are ignored, leaving the latch and status bits unchanged, unless `bit_cnt` is a multiple of 8 and at least 40, 32, 8 and 16 clocks respectively.
- R4: A well-formed modify instruction with the write latch clear raises `deny` and no grant.
- R5: Every well-formed modify instruction clears the write latch, whether it is granted or refused.
- R6: With the sector taken as the top 6 address bits, block-protect code n protects nothing for 0, all 64 sectors for 7, and otherwise the top 2^(n-1) sectors; a program or sector erase aimed at a protected sector raises `deny`.
- R7: Chip erase (0x60 or 0xC7) is granted only when all three block-protect bits are 0, and is refused otherwise.
- R8: A granted status write loads block-protect from data bits [4:2] and status-write-disable from bit 7; when `wp_n` is 0 and status-write-disable is 1 the status write is refused and no bit changes.
- R9: Opcode 0xB9 enters power-down; while in it every instruction except 0xAB is ignored, and 0xAB leaves it.
- R10: While `exec_busy` is 1, program, erase and status-write instructions are dropped: no pulse, latch and status bits unchanged.
- R11: Sector erase is recognised under both 0x20 and 0xD8 and grants `go_sect`; page program grants `go_prog`.
- R12: Grant and refusal pulses appear on the clock after `cs_rise`, last one clock and are mutually exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_rise | input | 1 | One-clock strobe: transaction ended |
| opcode | input | 8 | Decoded instruction byte |
| addr | input | ADDR_W | Target address of the transaction |
| bit_cnt | input | CNT_W | Serial clocks seen during the transaction |
| sr_data | input | 8 | First data byte, used by status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| exec_busy | input | 1 | Executor is running an operation |
| wel | output | 1 | Write enable latch |
| bp | output | 3 | Block-protect code |
| srwd | output | 1 | Status-write-disable bit |
| deep_pd | output | 1 | Deep power-down flag |
| go_prog | output | 1 | Page program granted |
| go_sect | output | 1 | Sector erase granted |
| go_chip | output | 1 | Chip erase granted |
| deny | output | 1 | Well-formed modify instruction refused |

## Verification
On every cycle the assertions hold the pulse discipline, that every grant was preceded by a set latch that is now clear, that chip erase never passes with a non-zero protect code, that busy time yields no grant, and that power-down and the hardware lock freeze the state. The region table, the length filter, the opcode aliases and the exact status-bit positions can only be shown by the bench's scenarios, which aim program and erase at sectors just inside and just outside each protected region and replay transactions with short and misaligned clock counts.

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int ADDR_W = 22,
  parameter int SECT_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [7:0]        sr_data,
  input  logic              wp_n,
  input  logic              exec_busy,
  output logic              wel,
  output logic [2:0]        bp,
  output logic              srwd,
  output logic              deep_pd,
  output logic              go_prog,
  output logic              go_sect,
  output logic              go_chip,
  output logic              deny
);
  localparam logic [SECT_W:0] NSECT = (SECT_W+1)'(1) << SECT_W;
  localparam logic [SECT_W:0] ONE   = (SECT_W+1)'(1);

  wire [SECT_W-1:0] sect = addr[ADDR_W-1 -: SECT_W];
  wire unused_bits = &{1'b0, addr[ADDR_W-SECT_W-1:0], sr_data[6:5], sr_data[1:0]};

  wire is_pp   = opcode == 8'h02;
  wire is_se   = opcode == 8'h20 || opcode == 8'hD8;
  wire is_ce   = opcode == 8'h60 || opcode == 8'hC7;
  wire is_wrsr = opcode == 8'h01;
  wire modify  = is_pp | is_se | is_ce | is_wrsr;

  logic [CNT_W-1:0] need;
  always_comb begin
    if (is_pp)       need = CNT_W'(40);
    else if (is_se)  need = CNT_W'(32);
    else if (is_wrsr) need = CNT_W'(16);
    else             need = CNT_W'(8);
  end

  wire len_ok = bit_cnt[2:0] == 3'd0 && bit_cnt >= need;
  wire live   = cs_rise && !deep_pd;
  wire take   = live && modify && len_ok && !exec_busy;

  logic zone;
  always_comb begin
    case (bp)
      3'd0:    zone = 1'b0;
      3'd7:    zone = 1'b1;
      default: zone = {1'b0, sect} >= (NSECT - (ONE << (bp - 3'd1)));
    endcase
  end

  wire blocked = !wel
               | ((is_pp | is_se) & zone)
               | (is_ce & (bp != 3'd0))
               | (is_wrsr & !wp_n & srwd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; bp <= 3'd0; srwd <= 1'b0; deep_pd <= 1'b0;
      go_prog <= 1'b0; go_sect <= 1'b0; go_chip <= 1'b0; deny <= 1'b0;
    end else begin
      go_prog <= 1'b0; go_sect <= 1'b0; go_chip <= 1'b0; deny <= 1'b0;
      if (take) begin
        wel <= 1'b0;
        if (blocked) deny <= 1'b1;
        else begin
          go_prog <= is_pp;
          go_sect <= is_se;
          go_chip <= is_ce;
          if (is_wrsr) begin
            bp   <= sr_data[4:2];
            srwd <= sr_data[7];
          end
        end
      end else if (live && !modify) begin
        case (opcode)
          8'h06:   wel <= 1'b1;
          8'h04:   wel <= 1'b0;
          8'hB9:   deep_pd <= 1'b1;
          default: ;
        endcase
      end
      if (cs_rise && deep_pd && opcode == 8'hAB) deep_pd <= 1'b0;
    end
  end
endmodule

module flash_wp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_rise,
  input logic [7:0] opcode,
  input logic       wp_n,
  input logic       exec_busy,
  input logic       wel,
  input logic [2:0] bp,
  input logic       srwd,
  input logic       deep_pd,
  input logic       go_prog,
  input logic       go_sect,
  input logic       go_chip,
  input logic       deny
);
  wire grant = go_prog | go_sect | go_chip;

  assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_prog, go_sect, go_chip, deny}));

  assert_after_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant | deny) |-> $past(cs_rise));

  assert_latch_used_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ($past(wel) && !wel));

  assert_chip_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go_chip |-> ($past(bp) == 3'd0));

  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exec_busy) |-> !grant);

  assert_sleep_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(deep_pd) && deep_pd) |-> ($stable(wel) && $stable(bp) && $stable(srwd)));

  assert_hw_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wp_n) && $past(srwd)) |-> ($stable(bp) && $stable(srwd)));

  assert_wren_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_rise) && $past(opcode) == 8'h06 && $past(!deep_pd)) |-> wel);
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .opcode(opcode), .wp_n(wp_n),
  .exec_busy(exec_busy), .wel(wel), .bp(bp), .srwd(srwd), .deep_pd(deep_pd),
  .go_prog(go_prog), .go_sect(go_sect), .go_chip(go_chip), .deny(deny)
);

// File: tb/sim_flash_wp_ctrl.sv
`timescale 1ns/1ps
module sim_flash_wp_ctrl;
  logic clk = 0, rst_n = 0, cs_rise = 0, wp_n = 1, exec_busy = 0;
  logic [7:0] opcode = 0, sr_data = 0;
  logic [21:0] addr = 0;
  logic [15:0] bit_cnt = 0;
  logic wel, srwd, deep_pd, go_prog, go_sect, go_chip, deny;
  logic [2:0] bp;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  flash_wp_ctrl u0 (.clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .opcode(opcode),
    .addr(addr), .bit_cnt(bit_cnt), .sr_data(sr_data), .wp_n(wp_n),
    .exec_busy(exec_busy), .wel(wel), .bp(bp), .srwd(srwd), .deep_pd(deep_pd),
    .go_prog(go_prog), .go_sect(go_sect), .go_chip(go_chip), .deny(deny));

  // behavioural reference model
  int m_wel, m_bp, m_srwd, m_dpd, e_prog, e_sect, e_chip, e_deny;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wel = 0; m_bp = 0; m_srwd = 0; m_dpd = 0;
      e_prog = 0; e_sect = 0; e_chip = 0; e_deny = 0;
    end else begin
      int kind, need, sector;
      bit refuse, prot;
      e_prog = 0; e_sect = 0; e_chip = 0; e_deny = 0;
      if (cs_rise) begin
        if (m_dpd) begin
          if (opcode == 8'hAB) m_dpd = 0;
        end else begin
          kind = 0; need = 0;
          if (opcode == 8'h02) begin kind = 1; need = 40; end
          if (opcode == 8'h20 || opcode == 8'hD8) begin kind = 2; need = 32; end
          if (opcode == 8'h60 || opcode == 8'hC7) begin kind = 3; need = 8; end
          if (opcode == 8'h01) begin kind = 4; need = 16; end
          if (kind != 0) begin
            if (!exec_busy && bit_cnt % 8 == 0 && int'(bit_cnt) >= need) begin
              sector = int'(addr) / 65536;
              prot = (m_bp == 7) || (m_bp != 0 && sector >= 64 - (1 << (m_bp - 1)));
              refuse = (m_wel == 0) || ((kind == 1 || kind == 2) && prot)
                    || (kind == 3 && m_bp != 0) || (kind == 4 && !wp_n && m_srwd == 1);
              m_wel = 0;
              if (refuse) e_deny = 1;
              else if (kind == 1) e_prog = 1;
              else if (kind == 2) e_sect = 1;
              else if (kind == 3) e_chip = 1;
              else begin m_bp = int'(sr_data[4:2]); m_srwd = int'(sr_data[7]); end
            end
          end else if (opcode == 8'h06) m_wel = 1;
          else if (opcode == 8'h04) m_wel = 0;
          else if (opcode == 8'hB9) m_dpd = 1;
        end
      end
    end
  end

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(int'(wel), m_wel, "R5 model wel");
    chk(int'(bp), m_bp, "R8 model bp");
    chk(int'(srwd), m_srwd, "R8 model srwd");
    chk(int'(deep_pd), m_dpd, "R9 model power-down");
    chk(int'({go_prog, go_sect, go_chip, deny}),
        e_prog*8 + e_sect*4 + e_chip*2 + e_deny, "R4 model pulses");
  end

  task automatic txn(input logic [7:0] op, input logic [21:0] a, input int n, input logic [7:0] d);
    @(negedge clk);
    opcode = op; addr = a; bit_cnt = 16'(n); sr_data = d; cs_rise = 1;
    @(negedge clk);
    cs_rise = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(int'({wel, bp, srwd, deep_pd, go_prog, go_sect, go_chip, deny}), 0, "R1 reset state");

    txn(8'h06, 0, 8, 0);  chk(int'(wel), 1, "R2 write enable");
    txn(8'h04, 0, 8, 0);  chk(int'(wel), 0, "R2 write disable");
    txn(8'h02, 0, 40, 0); chk(int'(deny), 1, "R4 program without latch");

    txn(8'h06, 0, 8, 0);
    txn(8'h02, 0, 44, 0); chk(int'({go_prog, deny}), 0, "R3 misaligned count");
    chk(int'(wel), 1, "R3 latch kept");
    txn(8'h02, 0, 32, 0); chk(int'({go_prog, deny}), 0, "R3 short program");
    txn(8'h02, 0, 40, 0); chk(int'(go_prog), 1, "R11 program grant");
    chk(int'(wel), 0, "R5 latch cleared on grant");
    @(negedge clk); chk(int'(go_prog), 0, "R12 single-cycle pulse");

    txn(8'h06, 0, 8, 0); txn(8'h01, 0, 16, 8'h0C); chk(int'(bp), 3, "R8 protect code load");
    txn(8'h06, 0, 8, 0); txn(8'hD8, 22'h3C0000, 32, 0); chk(int'(deny), 1, "R6 sector 60 protected");
    chk(int'(wel), 0, "R5 latch cleared on refusal");
    txn(8'h06, 0, 8, 0); txn(8'h20, 22'h3B0000, 32, 0); chk(int'(go_sect), 1, "R6 R11 sector 59 open");
    txn(8'h06, 0, 8, 0); txn(8'hC7, 0, 8, 0); chk(int'(deny), 1, "R7 chip erase blocked");

    txn(8'h06, 0, 8, 0); txn(8'h01, 0, 16, 8'h04); chk(int'(bp), 1, "R8 code one");
    txn(8'h06, 0, 8, 0); txn(8'h02, 22'h3F0000, 40, 0); chk(int'(deny), 1, "R6 sector 63 protected");
    txn(8'h06, 0, 8, 0); txn(8'h02, 22'h3E0000, 40, 0); chk(int'(go_prog), 1, "R6 sector 62 open");

    txn(8'h06, 0, 8, 0); txn(8'h01, 0, 16, 8'h80);
    wp_n = 0;
    txn(8'h06, 0, 8, 0); txn(8'h01, 0, 16, 8'h1C); chk(int'(deny), 1, "R8 hardware lock");
    chk(int'({srwd, bp}), 8, "R8 bits unchanged");
    wp_n = 1;
    txn(8'h06, 0, 8, 0); txn(8'h01, 0, 16, 8'h1C); chk(int'(bp), 7, "R8 unlocked write");
    txn(8'h06, 0, 8, 0); txn(8'h02, 0, 40, 0); chk(int'(deny), 1, "R6 all protected");
    txn(8'h06, 0, 8, 0); txn(8'h01, 0, 16, 8'h00);
    txn(8'h06, 0, 8, 0); txn(8'h60, 0, 8, 0); chk(int'(go_chip), 1, "R7 chip erase granted");

    txn(8'h06, 0, 8, 0);
    exec_busy = 1;
    txn(8'h02, 0, 40, 0); chk(int'({go_prog, deny}), 0, "R10 busy drop");
    chk(int'(wel), 1, "R10 latch kept");
    exec_busy = 0;

    txn(8'hB9, 0, 8, 0);  chk(int'(deep_pd), 1, "R9 enter power-down");
    txn(8'h04, 0, 8, 0);  chk(int'(wel), 1, "R9 disable ignored");
    txn(8'h02, 0, 40, 0); chk(int'({go_prog, deny}), 0, "R9 program ignored");
    txn(8'hAB, 0, 8, 0);  chk(int'(deep_pd), 0, "R9 release");
    txn(8'h02, 0, 40, 0); chk(int'(go_prog), 1, "R9 latch survived power-down");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule